// File: doc/BRIEF.md
# Address-Decoded Mode Flag Bank

This block holds twelve single-bit mode flags that a processor controls only by touching fixed addresses in the 256-byte I/O page 0xC000-0xC0FF of a 16-bit address, 8-bit data bus. Each flag owns three addresses: one clears it, one sets it and one reports it. Writes to the set or clear address always act, and the data on the bus is never looked at, so the block has no data input. Four of the flags also change when their set or clear address is read. A handful of extra addresses are only acknowledged on reads, so that an outer bus multiplexer sees a response for them.

The block samples the address and the strobes on each rising clock edge. The flag vector updates at that edge. A registered hit bit and read-data byte, valid for the cycle after the access, tell the outer multiplexer that this block answered and what it returned. Any other device in the I/O page lies outside this block.

Top module: `softswitch_bank`

## Requirements
- R1: While `rst_n` is low at a rising edge, all flags, `hit` and `rdata` become 0.
- R2: A write (`wr`=1) to a flag's set address sets that flag and a write to its clear address clears it; no other flag changes and `hit` is 1 with `rdata` 0x00 in the next cycle. Flag bit index with clear/set/status addresses: bit 0 C006/C007/C015, bit 1 C000/C001/C018, bit 2 C002/C003/C013, bit 3 C004/C005/C014, bit 4 C008/C009/C016, bit 5 C00A/C00B/C017, bit 6 C00E/C00F/C01E, bit 7 C00C/C00D/C01F, bit 8 C050/C051/C01A, bit 9 C052/C053/C01B, bit 10 C054/C055/C01C, bit 11 C056/C057/C01D.
- R3: A read (`rd`=1, `wr`=0) of a status address returns 0x80 when the flag is 1 and 0x00 when it is 0, sets `hit`, and changes no flag.
- R4: Flags 8 to 11 are read-sensitive: a read of their set or clear address sets or clears the flag and returns 0xFF with `hit` 1.
- R5: A read of the set or clear address of flags 0 to 7 changes no flag, and gives `hit` 0 and `rdata` 0x00.
- R6: Reads of C058, C05A, C05D, C05F, C061 and C062 give `hit` 1, `rdata` 0x00 and no flag change.
- R7: An access outside 0xC000-0xC0FF, or to an in-page address not listed in R2 or R6, changes no flag and gives `hit` 0 and `rdata` 0x00.
- R8: A write to a status address or to an R6 address changes no flag and gives `hit` 0.
- R9: `hit` and `rdata` are registered: they reflect the access sampled at the previous rising edge, and a cycle with neither strobe gives `hit` 0 and `rdata` 0x00.
- R10: When `rd` and `wr` are both 1, the access is treated as a write only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | 16 | Bus address |
| rd | input | 1 | Read strobe for this cycle |
| wr | input | 1 | Write strobe for this cycle |
| flags | output | 12 | Current flag vector, bit index as in R2 |
| rdata | output | 8 | Read data for the access of the previous cycle |
| hit | output | 1 | The access of the previous cycle matched a decoded address |

## Verification
Directed sequences walk every flag through write-set, status read, write-clear and status read, which separates the per-flag address pairing and the status polarity; the read-sensitive flags are then toggled by reads alone, while the same reads on write-only flags must leave the vector untouched. Quiet addresses, writes to status addresses, reads and writes to out-of-page aliases of decoded low bytes, and both strobes together are tried to tell apart page decoding, read-versus-write qualification and the write-over-read rule. A long seeded random stream, weighted toward the low part of the I/O page, mixes all of these against a bench model of the flag vector, checking flags, hit and read data after every access.

// File: rtl/ssw_pkg.sv
// Package: shared parameters and address tables of the mode flag bank.
// Assumes every set address is the clear address with bit 0 set.
package ssw_pkg;

    localparam int SSW_NUM_FLAGS  = 12;
    localparam int SSW_NUM_RDSENS = 4;
    localparam int SSW_ADDR_W     = 16;
    localparam int SSW_DATA_W     = 8;
    localparam logic [7:0] SSW_PAGE_HI = 8'hC0;

    // Low byte of the clear address of flag i.
    function automatic logic [7:0] clr_lo(input int i);
        case (i)
            0:  return 8'h06;
            1:  return 8'h00;
            2:  return 8'h02;
            3:  return 8'h04;
            4:  return 8'h08;
            5:  return 8'h0A;
            6:  return 8'h0E;
            7:  return 8'h0C;
            8:  return 8'h50;
            9:  return 8'h52;
            10: return 8'h54;
            default: return 8'h56;
        endcase
    endfunction

    // Low byte of the set address of flag i.
    function automatic logic [7:0] set_lo(input int i);
        return clr_lo(i) | 8'h01;
    endfunction

    // Low byte of the status address of flag i.
    function automatic logic [7:0] sts_lo(input int i);
        case (i)
            0:  return 8'h15;
            1:  return 8'h18;
            2:  return 8'h13;
            3:  return 8'h14;
            4:  return 8'h16;
            5:  return 8'h17;
            6:  return 8'h1E;
            7:  return 8'h1F;
            8:  return 8'h1A;
            9:  return 8'h1B;
            10: return 8'h1C;
            default: return 8'h1D;
        endcase
    endfunction

    // True for low bytes that are acknowledged on reads without any effect.
    function automatic logic is_quiet(input logic [7:0] lo);
        case (lo)
            8'h58, 8'h5A, 8'h5D, 8'h5F, 8'h61, 8'h62: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/ssw_decode.sv
// Address decoder of the mode flag bank.
// Produces per-flag set, clear and status matches for the current access,
// qualified by page, strobe and flag attribute. A read with wr also high is
// treated as a write. Status matches outrank set/clear matches.
module ssw_decode
    import ssw_pkg::*;
#(
    parameter int NUM_FLAGS  = SSW_NUM_FLAGS,
    parameter int NUM_RDSENS = SSW_NUM_RDSENS,
    parameter int ADDR_W     = SSW_ADDR_W
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 rd,
    input  logic                 wr,
    output logic [NUM_FLAGS-1:0] set_m,
    output logic [NUM_FLAGS-1:0] clr_m,
    output logic [NUM_FLAGS-1:0] sts_m,
    output logic                 quiet_m,
    output logic                 rd_only
);
    localparam int FIRST_RS = NUM_FLAGS - NUM_RDSENS;

    logic                 in_page;
    logic [7:0]           lo;
    logic [NUM_FLAGS-1:0] set_raw;
    logic [NUM_FLAGS-1:0] clr_raw;

    assign in_page = (addr[ADDR_W-1:8] == SSW_PAGE_HI);
    assign lo      = addr[7:0];
    assign rd_only = rd & ~wr;

    // One comparator set per flag; read sensitivity chosen by flag index.
    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        localparam logic RD_SENS = (g >= FIRST_RS);
        logic acc_ok;
        assign acc_ok     = wr | (RD_SENS & rd_only);
        assign sts_m[g]   = in_page & rd_only & (lo == sts_lo(g));
        assign set_raw[g] = in_page & acc_ok & (lo == set_lo(g));
        assign clr_raw[g] = in_page & acc_ok & (lo == clr_lo(g));
    end

    // Status matches take priority over set and clear matches.
    assign set_m   = set_raw & {NUM_FLAGS{~|sts_m}};
    assign clr_m   = clr_raw & {NUM_FLAGS{~|sts_m}};
    assign quiet_m = in_page & rd_only & is_quiet(lo) & ~|sts_m & ~|set_raw & ~|clr_raw;

endmodule

// File: rtl/ssw_flags.sv
// Flag register of the mode flag bank.
// Assumes set and clear matches never target the same flag in one cycle.
module ssw_flags #(
    parameter int NUM_FLAGS = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_FLAGS-1:0] set_m,
    input  logic [NUM_FLAGS-1:0] clr_m,
    output logic [NUM_FLAGS-1:0] flags
);
    // Hold the flags; apply decoded set and clear requests each edge.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags | set_m) & ~clr_m;
    end
endmodule

// File: rtl/ssw_readback.sv
// Registered response of the mode flag bank.
// Status reads report the flag in the top data bit, read-triggered set or
// clear returns all ones, everything else returns zero.
module ssw_readback #(
    parameter int NUM_FLAGS = 12,
    parameter int DATA_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_FLAGS-1:0] set_m,
    input  logic [NUM_FLAGS-1:0] clr_m,
    input  logic [NUM_FLAGS-1:0] sts_m,
    input  logic                 quiet_m,
    input  logic                 rd_only,
    input  logic [NUM_FLAGS-1:0] flags,
    output logic [DATA_W-1:0]    rdata,
    output logic                 hit
);
    localparam logic [DATA_W-1:0] STS_ON = {1'b1, {(DATA_W-1){1'b0}}};

    logic [DATA_W-1:0] rdata_nxt;

    // Pick the byte returned for this access.
    always_comb begin
        if (|sts_m)
            rdata_nxt = (|(sts_m & flags)) ? STS_ON : '0;
        else if (rd_only & (|set_m | |clr_m))
            rdata_nxt = '1;
        else
            rdata_nxt = '0;
    end

    // Register hit and data for the cycle after the access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit   <= 1'b0;
            rdata <= '0;
        end else begin
            hit   <= |sts_m | |set_m | |clr_m | quiet_m;
            rdata <= rdata_nxt;
        end
    end
endmodule

// File: rtl/softswitch_bank.sv
// Top of the mode flag bank: decoder, flag register and response register.
// Assumes one bus access per cycle, qualified by rd/wr.
module softswitch_bank
    import ssw_pkg::*;
#(
    parameter int NUM_FLAGS  = SSW_NUM_FLAGS,
    parameter int NUM_RDSENS = SSW_NUM_RDSENS,
    parameter int ADDR_W     = SSW_ADDR_W,
    parameter int DATA_W     = SSW_DATA_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 rd,
    input  logic                 wr,
    output logic [NUM_FLAGS-1:0] flags,
    output logic [DATA_W-1:0]    rdata,
    output logic                 hit
);
    logic [NUM_FLAGS-1:0] set_m;
    logic [NUM_FLAGS-1:0] clr_m;
    logic [NUM_FLAGS-1:0] sts_m;
    logic                 quiet_m;
    logic                 rd_only;

    ssw_decode #(
        .NUM_FLAGS (NUM_FLAGS),
        .NUM_RDSENS(NUM_RDSENS),
        .ADDR_W    (ADDR_W)
    ) u_decode (
        .addr   (addr),
        .rd     (rd),
        .wr     (wr),
        .set_m  (set_m),
        .clr_m  (clr_m),
        .sts_m  (sts_m),
        .quiet_m(quiet_m),
        .rd_only(rd_only)
    );

    ssw_flags #(
        .NUM_FLAGS(NUM_FLAGS)
    ) u_flags (
        .clk  (clk),
        .rst_n(rst_n),
        .set_m(set_m),
        .clr_m(clr_m),
        .flags(flags)
    );

    ssw_readback #(
        .NUM_FLAGS(NUM_FLAGS),
        .DATA_W   (DATA_W)
    ) u_readback (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_m  (set_m),
        .clr_m  (clr_m),
        .sts_m  (sts_m),
        .quiet_m(quiet_m),
        .rd_only(rd_only),
        .flags  (flags),
        .rdata  (rdata),
        .hit    (hit)
    );

endmodule

// File: rtl/softswitch_bank_checker.sv
// Checker for the mode flag bank, bound to the top module.
// Written for the default 12-flag, 16-bit address configuration.
module softswitch_bank_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] addr,
    input logic        rd,
    input logic        wr,
    input logic [11:0] flags,
    input logic [7:0]  rdata,
    input logic        hit
);
    // Reset clears all state.
    p_reset_clear_r1: assert property (@(posedge clk) !rst_n |=> (flags == 12'h0) && !hit && (rdata == 8'h00))
        else $error("reset did not clear state");

    // Writing C007 sets flag 0.
    p_write_set_r2: assert property (@(posedge clk) disable iff (!rst_n) (wr && addr == 16'hC007) |=> flags[0])
        else $error("write to set address did not set flag 0");

    // Reads in C010-C01F never change flags.
    p_status_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !wr && addr[15:4] == 12'hC01) |=> flags == $past(flags))
        else $error("status read changed flags");

    // Reading C051 sets flag 8 and answers all ones.
    p_read_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !wr && addr == 16'hC051) |=> flags[8] && hit && rdata == 8'hFF)
        else $error("read of C051 misbehaved");

    // Reads in C000-C00F have no effect and no hit.
    p_wo_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !wr && addr[15:4] == 12'hC00) |=> flags == $past(flags) && !hit)
        else $error("read of write-only address had an effect");

    // Out-of-page accesses are ignored.
    p_outside_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[15:8] != 8'hC0) |=> flags == $past(flags) && !hit)
        else $error("out-of-page access had an effect");

    // Idle cycles give no response.
    p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd && !wr) |=> !hit && rdata == 8'h00 && flags == $past(flags))
        else $error("idle cycle produced a response");

    // Hit is never asserted without a preceding strobe.
    p_hit_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hit) |-> $past(rd || wr))
        else $error("hit without access");
endmodule

bind softswitch_bank softswitch_bank_checker u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .addr (addr),
    .rd   (rd),
    .wr   (wr),
    .flags(flags),
    .rdata(rdata),
    .hit  (hit)
);

// File: tb/softswitch_bank_test.sv
// Self-checking bench for the mode flag bank: directed cases plus seeded random.
module softswitch_bank_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = 16'h0000;
    logic        rd = 1'b0;
    logic        wr = 1'b0;
    logic [11:0] flags;
    logic [7:0]  rdata;
    logic        hit;

    int n_checks = 0;
    int n_errors = 0;
    logic [11:0] m_flags = 12'h0;
    logic        done = 1'b0;

    always #2.5 clk = ~clk;

    softswitch_bank uut (
        .clk  (clk),
        .rst_n(rst_n),
        .addr (addr),
        .rd   (rd),
        .wr   (wr),
        .flags(flags),
        .rdata(rdata),
        .hit  (hit)
    );

    // Address table from the requirement list (R2).
    function automatic logic [15:0] a_clr(input int i);
        logic [7:0] t [12] = '{8'h06, 8'h00, 8'h02, 8'h04, 8'h08, 8'h0A,
                               8'h0E, 8'h0C, 8'h50, 8'h52, 8'h54, 8'h56};
        return {8'hC0, t[i]};
    endfunction
    function automatic logic [15:0] a_set(input int i);
        logic [7:0] t [12] = '{8'h07, 8'h01, 8'h03, 8'h05, 8'h09, 8'h0B,
                               8'h0F, 8'h0D, 8'h51, 8'h53, 8'h55, 8'h57};
        return {8'hC0, t[i]};
    endfunction
    function automatic logic [15:0] a_sts(input int i);
        logic [7:0] t [12] = '{8'h15, 8'h18, 8'h13, 8'h14, 8'h16, 8'h17,
                               8'h1E, 8'h1F, 8'h1A, 8'h1B, 8'h1C, 8'h1D};
        return {8'hC0, t[i]};
    endfunction
    function automatic bit quiet_addr(input logic [15:0] a);
        return a == 16'hC058 || a == 16'hC05A || a == 16'hC05D ||
               a == 16'hC05F || a == 16'hC061 || a == 16'hC062;
    endfunction

    // Reference model: update m_flags and give the expected response.
    task automatic model(input logic [15:0] a, input logic r, input logic w,
                         output logic e_hit, output logic [7:0] e_data, output string tag);
        e_hit = 1'b0; e_data = 8'h00; tag = "R7";
        if (w) begin
            tag = r ? "R10" : "R2";
            for (int i = 0; i < 12; i++) begin
                if (a == a_set(i)) begin m_flags[i] = 1'b1; e_hit = 1'b1; end
                if (a == a_clr(i)) begin m_flags[i] = 1'b0; e_hit = 1'b1; end
            end
            if (!e_hit) tag = "R8";
        end else if (r) begin
            for (int i = 0; i < 12; i++) begin
                if (a == a_sts(i)) begin
                    e_hit = 1'b1; e_data = m_flags[i] ? 8'h80 : 8'h00; tag = "R3";
                end
            end
            if (!e_hit) begin
                for (int i = 8; i < 12; i++) begin
                    if (a == a_set(i)) begin m_flags[i] = 1'b1; e_hit = 1'b1; e_data = 8'hFF; tag = "R4"; end
                    if (a == a_clr(i)) begin m_flags[i] = 1'b0; e_hit = 1'b1; e_data = 8'hFF; tag = "R4"; end
                end
                for (int i = 0; i < 8; i++)
                    if (a == a_set(i) || a == a_clr(i)) tag = "R5";
                if (!e_hit && quiet_addr(a)) begin e_hit = 1'b1; tag = "R6"; end
            end
        end else begin
            tag = "R9";
        end
    endtask

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // One access held for one cycle, outputs sampled after the edge.
    task automatic access(input logic [15:0] a, input logic r, input logic w);
        logic e_hit; logic [7:0] e_data; string tag;
        @(negedge clk);
        addr = a; rd = r; wr = w;
        model(a, r, w, e_hit, e_data, tag);
        @(posedge clk); #1;
        check(flags == m_flags, tag, "flags", {20'h0, flags}, {20'h0, m_flags});
        check(hit == e_hit && rdata == e_data, tag, "hit/rdata",
              {23'h0, hit, rdata}, {23'h0, e_hit, e_data});
    endtask

    // Watchdog: ends a hung run as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = 32'd12345;
        void'($urandom(seed));
        // R1: reset state after writes during reset are ignored
        repeat (3) @(negedge clk);
        addr = 16'hC007; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
        @(posedge clk); #1;
        check(flags == 12'h0 && !hit && rdata == 8'h00, "R1", "reset state",
              {19'h0, hit, flags}, 32'h0);
        @(negedge clk); rst_n = 1'b1;

        // R2/R3: walk each flag through set, status, clear, status
        for (int i = 0; i < 12; i++) begin
            access(a_set(i), 1'b0, 1'b1);
            access(a_sts(i), 1'b1, 1'b0);
            access(a_clr(i), 1'b0, 1'b1);
            access(a_sts(i), 1'b1, 1'b0);
            access(a_set(i), 1'b0, 1'b1);
        end
        // R5: reads of write-only set/clear addresses with flags 1
        for (int i = 0; i < 8; i++) begin
            access(a_clr(i), 1'b1, 1'b0);
            access(a_sts(i), 1'b1, 1'b0);
        end
        // R4: read-sensitive toggling by reads alone
        for (int i = 8; i < 12; i++) begin
            access(a_clr(i), 1'b1, 1'b0);
            access(a_sts(i), 1'b1, 1'b0);
            access(a_set(i), 1'b1, 1'b0);
            access(a_sts(i), 1'b1, 1'b0);
        end
        // R6: quiet reads
        foreach (m_flags[i]) if (i < 6) begin
            logic [15:0] q [6] = '{16'hC058, 16'hC05A, 16'hC05D, 16'hC05F, 16'hC061, 16'hC062};
            access(q[i], 1'b1, 1'b0);
        end
        // R8: writes to status and quiet addresses
        access(16'hC015, 1'b0, 1'b1);
        access(16'hC01A, 1'b0, 1'b1);
        access(16'hC058, 1'b0, 1'b1);
        // R7: out-of-page aliases and unlisted in-page addresses
        access(16'hD006, 1'b0, 1'b1);
        access(16'h0050, 1'b1, 1'b0);
        access(16'hC150, 1'b1, 1'b0);
        access(16'hC030, 1'b1, 1'b0);
        access(16'hC0FF, 1'b0, 1'b1);
        // R10: both strobes on a status and on a read-sensitive clear address
        access(16'hC01A, 1'b1, 1'b1);
        access(16'hC050, 1'b1, 1'b1);
        access(16'hC015, 1'b1, 1'b1);
        // R9: idle cycles
        access(16'hC051, 1'b0, 1'b0);
        access(16'hC015, 1'b0, 1'b0);

        // Seeded random mix, weighted to the low I/O page
        for (int k = 0; k < 4000; k++) begin
            logic [15:0] a; logic r; logic w; int sel;
            sel = $urandom_range(0, 9);
            if (sel < 7)      a = {8'hC0, 1'b0, 7'($urandom_range(0, 127))};
            else if (sel < 9) a = 16'($urandom);
            else              a = {8'($urandom), 8'($urandom_range(0, 95))};
            sel = $urandom_range(0, 9);
            r = (sel < 5) || (sel == 9);
            w = (sel >= 5 && sel < 8) || (sel == 9);
            access(a, r, w);
        end

        // R1: reset in mid-run clears set flags
        @(negedge clk); rst_n = 1'b0; rd = 1'b0; wr = 1'b0;
        @(posedge clk); #1;
        check(flags == 12'h0 && !hit, "R1", "mid-run reset", {19'h0, hit, flags}, 32'h0);
        m_flags = 12'h0;
        @(negedge clk); rst_n = 1'b1;
        access(16'hC01D, 1'b1, 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule